// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers thirty-two interrupt lines into a single active-low request for a processor. Each line has its own control word. The word picks one of four trigger kinds (low level, high level, falling edge, rising edge) and a three-bit priority. A line that is pending and enabled in the mask is a candidate. Among the candidates, the one with the highest priority is presented to software as a vector word equal to its number times four.

Software services an interrupt in two steps. It reads the encoded-vector register, which returns the winner and acknowledges it. The acknowledge releases the request line and clears an edge latch. Later, software writes any value to the end-of-service register. Between these two steps the request line stays released, even if other candidates are waiting.

All access goes through a simple synchronous 32-bit register bus. Read data is combinational in the cycle of the read strobe. Writes and the side effects of a read take effect at the clock edge. The source inputs are taken to be synchronous to the clock.

Top module: `vecIrqCtrl`

## Requirements
- R1: After reset, every source is masked, the controller is idle and not in service, `irqN` is high, and both the mask (0x114) and the last-number register (0x110) read 0.
- R2: The control word of source n is at byte address 4*n (n from 0 to 31). Bits 7:6 hold the trigger (0 low level, 1 high level, 2 falling edge, 3 rising edge) and bits 2:0 hold the priority. Only these bits are kept, and all other bits read 0.
- R3: A level-mode source is pending exactly while its input is at the selected level (trigger 0: input 0, trigger 1: input 1), or while its software latch is set.
- R4: An edge-mode source latches pending on the selected input transition and stays pending after the input returns. The opposite transition does not latch. The latch is cleared when that source is acknowledged.
- R5: Writing 0x120 enables every source whose data bit is 1. Writing 0x124 masks every source whose data bit is 1. Data bits that are 0 leave the mask unchanged. 0x114 reads the mask, with 1 meaning enabled.
- R6: Writing 0x128 sets, and writing 0x12C clears, the pending latch of each source whose data bit is 1. Data bits that are 0 have no effect.
- R7: The winner is the candidate with the highest priority, where 7 is the highest. On a tie, the lower source number wins. A masked source never wins.
- R8: When the controller is idle and a candidate exists at a clock edge, `irqN` goes low after that edge. If every candidate disappears before the acknowledge, `irqN` returns high after the next edge.
- R9: A read of 0x10C returns the winner's number shifted left by two, or 0 when there is no candidate. The read acknowledges: `irqN` is high after that edge, and 0x110 then reads the acknowledged number. When there was no candidate, 0x110 is left unchanged.
- R10: After an acknowledge, `irqN` stays high until any value is written to 0x130. If a candidate still exists, `irqN` goes low one edge after the edge that takes the write.
- R11: 0x100 reads the raw inputs, 0x104 the pending bits, and 0x108 the pending bits that are enabled. 0x118 reads bit 0 = request asserted and bit 1 = in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regRdEn | input | 1 | Register read strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle of `regRdEn` |
| srcIn | input | 32 | Raw interrupt inputs |
| irqN | output | 1 | Active-low interrupt request |

## Verification
Priority resolution is driven with a tie between two enabled sources at equal priority, where only the number can decide. It is then driven with a higher-priority source that is first masked and later enabled, so that the mask and the priority ordering are exposed one at a time. Each trigger kind is driven with both transitions or levels. A one-cycle pulse shows that an edge latch holds after the input returns, and the unselected transition shows that it does not latch. The service handshake is run with the source still asserted after the acknowledge, which separates the end-of-service gate from a plain level follow. A candidate that is withdrawn before the acknowledge shows that the request drops on its own. A cycle-level reference model is compared with `irqN` on every clock.

// File: rtl/vecIrqPkg.sv
package vecIrqPkg;

  localparam int REG_ADDR_W = 12;

  // register offsets; the source control words occupy 0 .. 4*NUM_SRC-1
  localparam int OFS_RAW     = 'h100;
  localparam int OFS_PEND    = 'h104;
  localparam int OFS_ENPEND  = 'h108;
  localparam int OFS_VECTOR  = 'h10C;
  localparam int OFS_LASTNUM = 'h110;
  localparam int OFS_MASK    = 'h114;
  localparam int OFS_OUTSTAT = 'h118;
  localparam int OFS_MASKON  = 'h120;
  localparam int OFS_MASKOFF = 'h124;
  localparam int OFS_FORCEON = 'h128;
  localparam int OFS_FORCEOFF= 'h12C;
  localparam int OFS_DONE    = 'h130;

  localparam int TRIG_LSB = 6;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_SERV = 2'd2
  } svc_state_e;

  typedef struct packed {
    logic ctrlWr;
    logic maskSet;
    logic maskClr;
    logic forceSet;
    logic forceClr;
    logic ack;
  } strobe_t;

endpackage

// File: rtl/vecIrqResolver.sv
module vecIrqResolver
  import vecIrqPkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             cand,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic [IDX_W-1:0]               winIdx,
  output logic                           anyCand
);

  logic [PRIO_W-1:0] bestPrio;

  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    bestPrio = '0;
    winIdx   = '0;
    anyCand  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!anyCand || prio[i] >= bestPrio)) begin
        anyCand  = 1'b1;
        bestPrio = prio[i];
        winIdx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/vecIrqControl.sv
module vecIrqControl
  import vecIrqPkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = REG_ADDR_W,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              anyCand,
  output strobe_t           stb,
  output logic              reqActive,
  output logic              inService,
  output logic              irqN
);

  svc_state_e state, stateNext;
  logic ctrlSel;
  logic doneWr;

  assign ctrlSel = (addr[ADDR_W-1:IDX_W+2] == '0) && (addr[1:0] == 2'b00);
  assign doneWr  = wrEn && (addr == ADDR_W'(OFS_DONE));

  always_comb begin
    stb          = '0;
    stb.ctrlWr   = wrEn && ctrlSel;
    stb.maskSet  = wrEn && (addr == ADDR_W'(OFS_MASKON));
    stb.maskClr  = wrEn && (addr == ADDR_W'(OFS_MASKOFF));
    stb.forceSet = wrEn && (addr == ADDR_W'(OFS_FORCEON));
    stb.forceClr = wrEn && (addr == ADDR_W'(OFS_FORCEOFF));
    stb.ack      = rdEn && (addr == ADDR_W'(OFS_VECTOR));
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (stb.ack) stateNext = ST_SERV;
               else if (anyCand) stateNext = ST_REQ;
      ST_REQ:  if (stb.ack) stateNext = ST_SERV;
               else if (!anyCand) stateNext = ST_IDLE;
      ST_SERV: if (doneWr) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqActive = (state == ST_REQ);
  assign inService = (state == ST_SERV);
  assign irqN      = ~reqActive;

  // a low request always stems from a candidate seen at the previous edge
  assert_req_has_cand_R8: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> $past(anyCand));

  // the acknowledge read releases the request line
  assert_ack_releases_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> irqN);

  // while in service, nothing but an end-of-service write lets irqN fall
  assert_done_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inService && !doneWr) |=> irqN);

endmodule

// File: rtl/vecIrqDatapath.sv
module vecIrqDatapath
  import vecIrqPkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = REG_ADDR_W,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  strobe_t            stb,
  input  logic               reqActive,
  input  logic               inService,
  output logic [DATA_W-1:0]  rdData,
  output logic               anyCand
);

  logic [NUM_SRC-1:0][1:0]        trigReg;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioReg;
  logic [NUM_SRC-1:0] maskReg, latchReg, prevIn;
  logic [NUM_SRC-1:0] levelHit, edgeHit, pending, cand;
  logic [NUM_SRC-1:0] setVec, clrVec, ackVec;
  logic               primed;
  logic [IDX_W-1:0]   winIdx, lastNum;
  logic [IDX_W-1:0]   ctrlIdx;
  logic               ctrlSel;

  assign ctrlIdx = addr[IDX_W+1:2];
  assign ctrlSel = (addr[ADDR_W-1:IDX_W+2] == '0) && (addr[1:0] == 2'b00);

  // per-source trigger detection
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_comb begin
      levelHit[g] = 1'b0;
      edgeHit[g]  = 1'b0;
      unique case (trig_e'(trigReg[g]))
        TRIG_LOW:  levelHit[g] = ~srcIn[g];
        TRIG_HIGH: levelHit[g] = srcIn[g];
        TRIG_FALL: edgeHit[g]  = primed & prevIn[g] & ~srcIn[g];
        TRIG_RISE: edgeHit[g]  = primed & ~prevIn[g] & srcIn[g];
        default:   levelHit[g] = 1'b0;
      endcase
    end
  end

  assign pending = levelHit | latchReg;
  assign cand    = pending & maskReg;

  vecIrqResolver #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) resolver_i (
    .cand    (cand),
    .prio    (prioReg),
    .winIdx  (winIdx),
    .anyCand (anyCand)
  );

  assign setVec = stb.forceSet ? wrData[NUM_SRC-1:0] : '0;
  assign clrVec = stb.forceClr ? wrData[NUM_SRC-1:0] : '0;
  assign ackVec = (stb.ack && anyCand) ? (NUM_SRC'(1) << winIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigReg  <= '0;
      prioReg  <= '0;
      maskReg  <= '0;
      latchReg <= '0;
      prevIn   <= '0;
      primed   <= 1'b0;
      lastNum  <= '0;
    end else begin
      if (stb.ctrlWr) begin
        trigReg[ctrlIdx] <= wrData[TRIG_LSB+1:TRIG_LSB];
        prioReg[ctrlIdx] <= wrData[PRIO_W-1:0];
      end
      if (stb.maskSet) maskReg <= maskReg | wrData[NUM_SRC-1:0];
      if (stb.maskClr) maskReg <= maskReg & ~wrData[NUM_SRC-1:0];
      latchReg <= (latchReg & ~clrVec & ~ackVec) | setVec | edgeHit;
      prevIn   <= srcIn;
      primed   <= 1'b1;
      if (stb.ack && anyCand) lastNum <= winIdx;
    end
  end

  always_comb begin
    rdData = '0;
    if (ctrlSel) begin
      rdData[TRIG_LSB+1:TRIG_LSB] = trigReg[ctrlIdx];
      rdData[PRIO_W-1:0]          = prioReg[ctrlIdx];
    end else if (addr == ADDR_W'(OFS_RAW))     rdData = DATA_W'(srcIn);
    else if (addr == ADDR_W'(OFS_PEND))        rdData = DATA_W'(pending);
    else if (addr == ADDR_W'(OFS_ENPEND))      rdData = DATA_W'(cand);
    else if (addr == ADDR_W'(OFS_VECTOR))      rdData = anyCand ? DATA_W'({winIdx, 2'b00}) : '0;
    else if (addr == ADDR_W'(OFS_LASTNUM))     rdData = DATA_W'(lastNum);
    else if (addr == ADDR_W'(OFS_MASK))        rdData = DATA_W'(maskReg);
    else if (addr == ADDR_W'(OFS_OUTSTAT))     rdData = DATA_W'({inService, reqActive});
  end

  // the resolver only ever names an enabled, pending source
  assert_winner_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyCand |-> (maskReg[winIdx] && pending[winIdx]));

  // enable command turns on every written one-bit
  assert_mask_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.maskSet |=> ((maskReg & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0])));

  // an acknowledged source no longer holds its latch one edge later
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && anyCand && !stb.forceSet) |=> ((latchReg & $past(ackVec) & ~$past(edgeHit)) == '0));

endmodule

// File: rtl/vecIrqCtrl.sv
module vecIrqCtrl
  import vecIrqPkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = REG_ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regRdEn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqN
);

  strobe_t stb;
  logic    anyCand, reqActive, inService;

  vecIrqControl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) control_i (
    .clk       (clk),
    .rstN      (rstN),
    .rdEn      (regRdEn),
    .wrEn      (regWrEn),
    .addr      (regAddr),
    .anyCand   (anyCand),
    .stb       (stb),
    .reqActive (reqActive),
    .inService (inService),
    .irqN      (irqN)
  );

  vecIrqDatapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .addr      (regAddr),
    .wrData    (regWrData),
    .stb       (stb),
    .reqActive (reqActive),
    .inService (inService),
    .rdData    (regRdData),
    .anyCand   (anyCand)
  );

  // R1: request line is released throughout reset
  always @(posedge clk) if (!rstN) assert_reset_idle_R1: assert (irqN !== 1'b0 || $time == 0);

endmodule

// File: tb/vecIrqCtrl_tb_top.sv
module vecIrqCtrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [31:0] srcIn = '0;
  logic        irqN;

  int checks = 0, fails = 0;
  bit started = 0;

  always #4 clk = ~clk;

  vecIrqCtrl dut_i (
    .clk(clk), .rstN(rstN), .regRdEn(rdEn), .regWrEn(wrEn), .regAddr(addr),
    .regWrData(wrData), .regRdData(rdData), .srcIn(srcIn), .irqN(irqN)
  );

  // ---------------- reference model ----------------
  bit [31:0] mMask, mLatch, mPrev;
  bit        mPrimed;
  bit [1:0]  mTrig [32];
  bit [2:0]  mPrio [32];
  int        mState;   // 0 idle, 1 requesting, 2 in service

  function automatic bit [31:0] mPend();
    bit [31:0] p = mLatch;
    for (int i = 0; i < 32; i++) begin
      if (mTrig[i] == 2'd0 && !srcIn[i]) p[i] = 1'b1;
      if (mTrig[i] == 2'd1 && srcIn[i])  p[i] = 1'b1;
    end
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mLatch = 0; mPrev = 0; mPrimed = 0; mState = 0;
      for (int i = 0; i < 32; i++) begin mTrig[i] = 0; mPrio[i] = 0; end
    end else begin
      bit [31:0] cand;
      bit any, ack, done;
      int win, best;
      cand = mPend() & mMask;
      any = 0; win = 0; best = -1;
      for (int i = 0; i < 32; i++)
        if (cand[i] && int'(mPrio[i]) > best) begin best = mPrio[i]; win = i; any = 1; end
      ack  = rdEn && addr == 12'h10C;
      done = wrEn && addr == 12'h130;
      for (int i = 0; i < 32; i++) begin
        if (mPrimed && mTrig[i] == 2'd3 && srcIn[i] && !mPrev[i]) mLatch[i] = 1;
        if (mPrimed && mTrig[i] == 2'd2 && !srcIn[i] && mPrev[i]) mLatch[i] = 1;
      end
      if (ack && any) mLatch[win] = 0;
      if (wrEn && addr == 12'h12C) mLatch = mLatch & ~wrData;
      if (wrEn && addr == 12'h128) mLatch = mLatch | wrData;
      if (wrEn && addr == 12'h120) mMask = mMask | wrData;
      if (wrEn && addr == 12'h124) mMask = mMask & ~wrData;
      if (wrEn && addr < 12'h80 && addr[1:0] == 0) begin
        mTrig[addr >> 2] = wrData[7:6];
        mPrio[addr >> 2] = wrData[2:0];
      end
      if (ack) mState = 2;
      else if (mState == 0 && any) mState = 1;
      else if (mState == 1 && !any) mState = 0;
      else if (mState == 2 && done) mState = 0;
      mPrev = srcIn; mPrimed = 1;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R8: request line follows the model on every clock
  always @(negedge clk) if (started && rstN) begin
    #1 check(irqN == (mState != 1), "R8 model irqN", irqN, (mState != 1));
  end

  task automatic busRd(int a, logic [31:0] exp, string tag);
    @(negedge clk); rdEn = 1; addr = 12'(a);
    #2 check(rdData === exp, tag, rdData, exp);
    @(posedge clk); #1 rdEn = 0;
  endtask

  task automatic busWr(int a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = 12'(a); wrData = d;
    @(posedge clk); #1 wrEn = 0;
  endtask

  task automatic setIn(logic [31:0] v);
    @(negedge clk); srcIn = v;
  endtask

  task automatic chkIrq(logic exp, string tag);
    @(negedge clk); #2 check(irqN === exp, tag, irqN, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; started = 1;
    // R1 reset state
    chkIrq(1, "R1 irqN after reset");
    busRd('h114, 0, "R1 mask reset");
    busRd('h110, 0, "R1 last number reset");
    busRd('h118, 0, "R11 outstat idle");
    // R3: reset trigger is low level, inputs low -> all pending
    busRd('h104, 32'hFFFF_FFFF, "R3 low level pending");
    busRd('h108, 0, "R11 enabled pending while masked");
    for (int i = 0; i < 32; i++) busWr(4 * i, 32'h40);
    busRd('h104, 0, "R3 high level idle");
    // R2 field retention
    busWr('h14, 32'hFFFF_FF7D);
    busRd('h14, 32'h45, "R2 control readback");
    // R5 mask commands
    busWr('h120, 32'h30);
    busRd('h114, 32'h30, "R5 mask enable");
    busWr('h124, 0);
    busRd('h114, 32'h30, "R5 zero disable no effect");
    // R8 request
    setIn(32'h20);
    chkIrq(0, "R8 request asserted");
    busRd('h100, 32'h20, "R11 raw status");
    busRd('h108, 32'h20, "R11 enabled pending");
    busRd('h118, 1, "R11 outstat request");
    // R9 acknowledge
    busRd('h10C, 20, "R9 vector of source 5");
    chkIrq(1, "R9 released after ack");
    busRd('h110, 5, "R9 last number");
    busRd('h118, 2, "R11 outstat in service");
    // R10 end-of-service gate
    idle(3);
    chkIrq(1, "R10 held while in service");
    busWr('h130, 0);
    chkIrq(1, "R10 idle edge after done");
    chkIrq(0, "R10 reasserts after done");
    busRd('h10C, 20, "R9 second ack");
    setIn(0);
    busWr('h130, 0);
    // R7 priority
    busWr('h10, 32'h45);
    busWr('h24, 32'h47);
    setIn(32'h230);
    idle(2);
    busRd('h10C, 16, "R7 tie goes to lower number, masked loses");
    busWr('h130, 0);
    busWr('h120, 32'h200);
    idle(2);
    busRd('h10C, 36, "R7 highest priority wins");
    busWr('h130, 0);
    setIn(0);
    busWr('h124, 32'h200);
    idle(2);
    // R8 withdrawal
    setIn(32'h10);
    chkIrq(0, "R8 request from source 4");
    setIn(0);
    chkIrq(1, "R8 withdrawn before ack");
    // R4 rising edge
    busWr('h30, 32'hC3);
    busWr('h120, 32'h1000);
    setIn(32'h1000);
    setIn(0);
    busRd('h104, 32'h1000, "R4 rising latched");
    busRd('h10C, 48, "R4 vector of source 12");
    busRd('h104, 0, "R4 latch cleared by ack");
    busWr('h130, 0);
    // R4 falling edge
    busWr('h34, 32'h82);
    busWr('h120, 32'h2000);
    setIn(32'h2000);
    busRd('h104, 0, "R4 opposite edge ignored");
    setIn(0);
    busRd('h104, 32'h2000, "R4 falling latched");
    // R6 force commands
    busWr('h12C, 0);
    busRd('h104, 32'h2000, "R6 zero clear no effect");
    busWr('h12C, 32'h2000);
    busRd('h104, 0, "R6 force clear");
    busWr('h128, 32'h10_0000);
    busRd('h104, 32'h10_0000, "R6 force set");
    busRd('h108, 0, "R11 forced but masked");
    busRd('h114, 32'h3030, "R5 mask readback");
    busWr('h12C, 32'h10_0000);
    // R3 low level on one source
    busWr('h1C, 32'h00);
    busRd('h104, 32'h80, "R3 low level active");
    setIn(32'h80);
    busRd('h104, 0, "R3 low level released");
    // R9 ack without candidate
    busRd('h10C, 0, "R9 empty vector");
    busRd('h110, 12, "R9 last number kept");
    busRd('h118, 2, "R11 in service after empty ack");
    busWr('h130, 0);
    busRd('h118, 0, "R11 idle after done");
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule